// File: doc/BRIEF.md
# Five-Port Dimension-Order Mesh Router

This block is the switching element of one node in a two-dimensional mesh. It has five input ports and five output ports: one pair for the attached node (Local) and one pair for each compass neighbour (East, West, North, South). Every flit is a whole packet. The flit header carries two signed hop counts, `dx` and `dy`. These give the distance still to travel along each axis.

Routing is strictly axis-ordered. The X distance is used up first, through East or West. The Y distance is then used up through North or South. A flit whose two counts are both zero is handed to the Local output. The router rewrites the count that belongs to the chosen axis as the flit departs. Each hop therefore sees the distance that remains from its own position.

The route depends only on the header, so the path is fixed, and every path is a shortest one. Because every packet takes all of its X channels before any Y channel, the channel dependences cannot form a cycle. Each input holds one flit in a single-entry buffer. Each output runs a rotating-priority arbiter over the five inputs.

Top module: `mesh_router`

## Requirements
- R1: A flit only leaves on North or South once its X count is zero; an outgoing North/South flit always carries `dx == 0`.
- R2: A flit with `dx > 0` leaves on East (port index 1) with `dx` reduced by one; a flit with `dx < 0` leaves on West (port index 2) with `dx` increased by one. `dy` is left unchanged in both cases, whatever its value.
- R3: A flit with `dx == 0` and `dy > 0` leaves on North (port index 3) with `dy` reduced by one; `dx == 0` and `dy < 0` leaves on South (port index 4) with `dy` increased by one.
- R4: A flit with `dx == 0` and `dy == 0` leaves on Local (port index 0) bit-for-bit unchanged.
- R5: An input with an empty buffer shows `in_ready` high. A flit accepted at a rising edge drives its output's `out_valid` from that edge on. The input's `in_ready` stays low until the flit departs. `in_ready` is high again on the edge at which the output accepts the flit.
- R6: While an output has `out_valid` high and `out_ready` low, the flit is held: `out_valid` stays high, and the buffered flit stays in its input buffer.
- R7: When several inputs compete for one output, grants rotate. After reset, input 0 (Local) has first priority. After each accepted grant, first priority moves to the input after the granted one, in the cyclic order 0,1,2,3,4.
- R8: Flit layout: bits [3:0] hold `dx` and bits [7:4] hold `dy`, each in 4-bit two's complement. The upper payload bits pass through unchanged.
- R9: While `rst_n` is low, every `out_valid` is low and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Per-input flit present (index 0 L, 1 E, 2 W, 3 N, 4 S) |
| in_data | input | 5x16 | Per-input flit |
| in_ready | output | 5 | Per-input buffer empty |
| out_valid | output | 5 | Per-output flit present |
| out_data | output | 5x16 | Per-output flit with rewritten header |
| out_ready | input | 5 | Per-output downstream can accept |

## Verification
A flit offered at one rising edge appears on its output right after that edge, because the path from buffer to output has no register. The input buffer frees up after the next edge at which the output accepts the flit. The bench changes inputs and reads outputs at the falling edge. Each route vector is checked one falling edge after injection, and the freed state one edge later. In the arbitration test, the grant order is read one falling edge per accepted flit. The backpressure test reads the held flit over several falling edges while `out_ready` is low.

// File: rtl/mr_pkg.sv
// Package: shared constants for the mesh router.
// Port indices set the cyclic arbitration order and are therefore fixed.
package mr_pkg;
    localparam int NUM_PORTS = 5;
    localparam int P_LOCAL   = 0;
    localparam int P_EAST    = 1;
    localparam int P_WEST    = 2;
    localparam int P_NORTH   = 3;
    localparam int P_SOUTH   = 4;
endpackage

// File: rtl/mr_in_buf.sv
// mr_in_buf: single-entry input buffer.
// Accepts a flit when empty and holds it until pop is asserted.
// Assumes pop is only raised while the buffer is full.
module mr_in_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic         buf_valid,
    output logic [W-1:0] buf_data
);
    logic         full_q;
    logic [W-1:0] data_q;

    // Ready only while empty, so in_ready never depends on downstream logic.
    assign in_ready  = ~full_q;
    assign buf_valid = full_q;
    assign buf_data  = data_q;

    // Occupancy: fill on handshake, drain on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    // Payload capture on accepted handshake only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (in_valid && !full_q) begin
            data_q <= in_data;
        end
    end
endmodule

// File: rtl/mr_route.sv
// mr_route: dimension-order route computation and header rewrite.
// X is exhausted before Y. Offsets are two's complement of OFS_W bits.
// Purely combinational; the result is one-hot over the five outputs.
module mr_route
    import mr_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int OFS_W     = 4
) (
    input  logic [PAYLOAD_W+2*OFS_W-1:0] flit_in,
    output logic [NUM_PORTS-1:0]         req_oh,
    output logic [PAYLOAD_W+2*OFS_W-1:0] flit_out
);
    localparam int FW = PAYLOAD_W + 2*OFS_W;

    logic [OFS_W-1:0] dx, dy, dx_n, dy_n;
    logic             dx_zero, dy_zero, dx_neg, dy_neg;

    assign dx      = flit_in[OFS_W-1:0];
    assign dy      = flit_in[2*OFS_W-1:OFS_W];
    assign dx_zero = (dx == '0);
    assign dy_zero = (dy == '0);
    assign dx_neg  = dx[OFS_W-1];
    assign dy_neg  = dy[OFS_W-1];

    // Pick the output and step the active offset one hop toward zero.
    always_comb begin
        req_oh = '0;
        dx_n   = dx;
        dy_n   = dy;
        if (!dx_zero) begin
            if (dx_neg) begin
                req_oh[P_WEST] = 1'b1;
                dx_n           = dx + 1'b1;
            end else begin
                req_oh[P_EAST] = 1'b1;
                dx_n           = dx - 1'b1;
            end
        end else if (!dy_zero) begin
            if (dy_neg) begin
                req_oh[P_SOUTH] = 1'b1;
                dy_n            = dy + 1'b1;
            end else begin
                req_oh[P_NORTH] = 1'b1;
                dy_n            = dy - 1'b1;
            end
        end else begin
            req_oh[P_LOCAL] = 1'b1;
        end
    end

    assign flit_out = {flit_in[FW-1:2*OFS_W], dy_n, dx_n};
endmodule

// File: rtl/mr_rr_arb.sv
// mr_rr_arb: rotating-priority arbiter over N requesters.
// The grant is combinational. The priority pointer moves to the entry after
// the granted one only when 'advance' signals that the grant was taken.
module mr_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] gidx;

    // Scan from the pointer upward, wrapping, and grant the first requester.
    always_comb begin
        logic found;
        grant = '0;
        gidx  = ptr_q;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                gidx       = PW'(idx);
                found      = 1'b1;
            end
        end
    end

    // Pointer update past the most recent accepted grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (int'(gidx) == N-1) ? '0 : gidx + 1'b1;
        end
    end
endmodule

// File: rtl/mesh_router.sv
// mesh_router: five-port 2D-mesh router with dimension-order routing.
// Each input has a single-entry buffer. Each output has a rotating-priority
// arbiter. The output path has no register, so a buffered flit is presented
// in the cycle after it is accepted. Each flit is a complete packet.
module mesh_router
    import mr_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int OFS_W     = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_PORTS-1:0]                         in_valid,
    input  logic [NUM_PORTS-1:0][PAYLOAD_W+2*OFS_W-1:0]  in_data,
    output logic [NUM_PORTS-1:0]                         in_ready,
    output logic [NUM_PORTS-1:0]                         out_valid,
    output logic [NUM_PORTS-1:0][PAYLOAD_W+2*OFS_W-1:0]  out_data,
    input  logic [NUM_PORTS-1:0]                         out_ready
);
    localparam int FW = PAYLOAD_W + 2*OFS_W;
    localparam int NP = NUM_PORTS;

    logic [NP-1:0]         buf_valid;
    logic [NP-1:0][FW-1:0] buf_data;
    logic [NP-1:0][FW-1:0] upd_data;
    logic [NP-1:0][NP-1:0] route_oh;   // [input][output]
    logic [NP-1:0][NP-1:0] req_col;    // [output][input]
    logic [NP-1:0][NP-1:0] gnt_col;    // [output][input]
    logic [NP-1:0]         pop;
    logic [NP-1:0]         advance;

    // Per-input buffer and route computation.
    for (genvar p = 0; p < NP; p++) begin : g_in
        mr_in_buf #(.W(FW)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[p]),
            .in_data   (in_data[p]),
            .in_ready  (in_ready[p]),
            .pop       (pop[p]),
            .buf_valid (buf_valid[p]),
            .buf_data  (buf_data[p])
        );

        mr_route #(.PAYLOAD_W(PAYLOAD_W), .OFS_W(OFS_W)) u_route (
            .flit_in  (buf_data[p]),
            .req_oh   (route_oh[p]),
            .flit_out (upd_data[p])
        );
    end

    // Transpose valid routes into per-output request columns.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_col[o][i] = buf_valid[i] & route_oh[i][o];
            end
        end
    end

    // Per-output arbiter.
    for (genvar o = 0; o < NP; o++) begin : g_out
        assign advance[o] = out_valid[o] & out_ready[o];

        mr_rr_arb #(.N(NP)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_col[o]),
            .advance (advance[o]),
            .grant   (gnt_col[o])
        );
    end

    // Output multiplexer: forward the granted input's rewritten flit.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            out_valid[o] = |gnt_col[o];
            out_data[o]  = '0;
            for (int i = 0; i < NP; i++) begin
                if (gnt_col[o][i]) out_data[o] = upd_data[i];
            end
        end
    end

    // Drain an input when its grant is accepted downstream.
    always_comb begin
        pop = '0;
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                if (gnt_col[o][i] && out_ready[o]) pop[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mr_checker.sv
// mr_checker: protocol and routing properties of mesh_router, attached by bind.
// Observes only the top-level ports.
module mr_checker
    import mr_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int OFS_W     = 4
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic [NUM_PORTS-1:0]                        in_valid,
    input logic [NUM_PORTS-1:0]                        in_ready,
    input logic [NUM_PORTS-1:0]                        out_valid,
    input logic [NUM_PORTS-1:0][PAYLOAD_W+2*OFS_W-1:0] out_data,
    input logic [NUM_PORTS-1:0]                        out_ready
);
    AST_NORTH_NO_X: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_NORTH] |-> (out_data[P_NORTH][OFS_W-1:0] == '0)); // R1
    AST_SOUTH_NO_X: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_SOUTH] |-> (out_data[P_SOUTH][OFS_W-1:0] == '0)); // R1
    AST_EAST_DX_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_EAST] |-> !out_data[P_EAST][OFS_W-1]); // R2
    AST_WEST_DX_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_WEST] |-> (out_data[P_WEST][OFS_W-1] ||
                               out_data[P_WEST][OFS_W-1:0] == '0)); // R2
    AST_LOCAL_AT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_LOCAL] |-> (out_data[P_LOCAL][2*OFS_W-1:0] == '0)); // R4

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_prop
        AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=> out_valid[p]); // R6
        AST_BUF_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[p] && in_ready[p]) |=> (!in_ready[p] && (out_valid != '0))); // R5
    end
endmodule

bind mesh_router mr_checker #(.PAYLOAD_W(PAYLOAD_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
    logic              clk = 1'b0;
    logic              rst_n;
    logic [4:0]        in_valid;
    logic [4:0][15:0]  in_data;
    logic [4:0]        in_ready;
    logic [4:0]        out_valid;
    logic [4:0][15:0]  out_data;
    logic [4:0]        out_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    mesh_router u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    // {in_port[2:0], flit[15:0], exp_port[2:0], exp_flit[15:0]}
    localparam logic [37:0] VEC [10] = '{
        {3'd0, 16'hA103, 3'd1, 16'hA102},   // R2 east
        {3'd2, 16'h5B2F, 3'd2, 16'h5B20},   // R2 west, dy kept
        {3'd4, 16'h3350, 3'd3, 16'h3340},   // R3 north
        {3'd3, 16'h7E80, 3'd4, 16'h7E90},   // R3 south from -8
        {3'd1, 16'hC400, 3'd0, 16'hC400},   // R4 local
        {3'd0, 16'h01D7, 3'd1, 16'h01D6},   // R1 X before Y
        {3'd3, 16'hFF18, 3'd2, 16'hFF19},   // R2 west from -8
        {3'd2, 16'h00F1, 3'd1, 16'h00F0},   // R1 X first with dy<0
        {3'd1, 16'h42F0, 3'd4, 16'h4200},   // R3 south to zero
        {3'd4, 16'h9910, 3'd3, 16'h9900}    // R8 payload kept
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = '0;
        in_data   = '0;
        out_ready = '1;
        repeat (2) @(negedge clk);
        // R9: reset state
        chk(out_valid == 5'h00, "R9 out_valid", 32'(out_valid), 0);
        chk(in_ready  == 5'h1F, "R9 in_ready", 32'(in_ready), 32'h1F);
        rst_n = 1'b1;

        // Route vectors: R1 R2 R3 R4 R8
        for (int v = 0; v < 10; v++) begin
            logic [2:0]  ip, ep;
            logic [15:0] fl, ef;
            {ip, fl, ep, ef} = VEC[v];
            @(negedge clk);
            in_valid[ip] = 1'b1;
            in_data[ip]  = fl;
            @(negedge clk);
            in_valid = '0;
            chk(out_valid == (5'b1 << ep), "R1/R2/R3/R4 out port", 32'(out_valid),
                32'(5'b1 << ep));
            chk(out_data[ep] == ef, "R8 rewritten flit", 32'(out_data[ep]), 32'(ef));
            chk(in_ready[ip] == 1'b0, "R5 buffer busy", 32'(in_ready[ip]), 0);
            @(negedge clk);
            chk(out_valid == 5'h00, "R5 drained", 32'(out_valid), 0);
            chk(in_ready == 5'h1F, "R5 ready again", 32'(in_ready), 32'h1F);
        end

        // R6: backpressure on East
        out_ready[1] = 1'b0;
        in_valid[0]  = 1'b1;
        in_data[0]   = 16'h6A01;
        @(negedge clk);
        in_valid = '0;
        for (int k = 0; k < 3; k++) begin
            chk(out_valid[1] == 1'b1, "R6 held valid", 32'(out_valid[1]), 1);
            chk(out_data[1] == 16'h6A00, "R6 held data", 32'(out_data[1]), 32'h6A00);
            chk(in_ready[0] == 1'b0, "R6 input blocked", 32'(in_ready[0]), 0);
            @(negedge clk);
        end
        out_ready[1] = 1'b1;
        @(negedge clk);
        chk(out_valid[1] == 1'b0, "R6 released", 32'(out_valid[1]), 0);
        chk(in_ready[0] == 1'b1, "R5 freed after release", 32'(in_ready[0]), 1);

        // R7: fresh reset, all five inputs contend for East
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        out_ready[1] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            in_valid[i] = 1'b1;
            in_data[i]  = {8'(i), 8'h01};
        end
        @(negedge clk);
        in_valid = '0;
        chk(in_ready == 5'h00, "R5 all buffers full", 32'(in_ready), 0);
        out_ready[1] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            chk(out_data[1] == {8'(k), 8'h00}, "R7 rotation order",
                32'(out_data[1]), 32'({8'(k), 8'h00}));
            @(negedge clk);
        end
        chk(out_valid[1] == 1'b0, "R7 all served", 32'(out_valid[1]), 0);

        // R7: pointer moves past last grant (input 2 -> next priority 3)
        in_valid[2] = 1'b1;
        in_data[2]  = 16'h2201;
        @(negedge clk);
        in_valid = '0;
        chk(out_data[1] == 16'h2200, "R7 lone grant", 32'(out_data[1]), 32'h2200);
        @(negedge clk);
        in_valid[0] = 1'b1;
        in_data[0]  = 16'h0A01;
        in_valid[4] = 1'b1;
        in_data[4]  = 16'h4A01;
        @(negedge clk);
        in_valid = '0;
        chk(out_data[1] == 16'h4A00, "R7 input 4 before 0", 32'(out_data[1]), 32'h4A00);
        @(negedge clk);
        chk(out_data[1] == 16'h0A00, "R7 input 0 after wrap", 32'(out_data[1]), 32'h0A00);
        @(negedge clk);
        chk(out_valid == 5'h00, "R7 idle", 32'(out_valid), 0);

        finish_run();
    end
endmodule